// File: doc/BRIEF.md
# Horizontally Microcoded 16-bit Processor Core

This block is a small processor datapath whose every control line comes straight from a 32-bit microword. Each cycle the core presents a micro-address, receives the matching microword from an external control store, and executes it in one clock. Execution means reading two registers onto the A and B buses, choosing the A operand from a register or the memory buffer, running one ALU function, and passing the result through a one-bit shifter. The shifted result is then written to a register, the memory buffer, or both. The same cycle can also load the memory address register from the B bus and pick the next micro-address, either sequentially or by a jump that depends on the ALU's sign or zero flag.

Memory traffic uses held strobes. A read or write strobe is raised in the cycle after the microword that asks for it. The transfer completes only if the next microword asks for the same access again. A microword that asks for a read and a write together stops the core until reset.

Top module: `mcpu_core`

## Requirements
- R1: During and right after reset the micro-address output is 0, both strobes and the halt output are low, and the memory address and memory data outputs are 0. Register 2 starts at SP_INIT (1024), every other writable register starts at 0, and register 0 serves as the program counter.
- R2: Registers 5, 6, 7, 8 and 9 always read 0x0000, 0x0001, 0xFFFF, 0x0FFF and 0x00FF, and writes to them have no effect.
- R3: Microword bits, most significant first: bit 31 A-select, bits 30:29 next-address condition, bits 28:27 ALU function, bits 26:25 shift, bit 24 buffer load, bit 23 address load, bit 22 read, bit 21 write, bit 20 register-write enable, bits 19:16 destination register, bits 15:12 B register, bits 11:8 A register, bits 7:0 jump target.
- R4: ALU function code 0 gives A+B modulo 2^16, code 1 gives A AND B, code 2 passes A, and code 3 gives NOT A.
- R5: Shift code 0 passes the ALU result, code 1 shifts it right by one and fills bit 15 with 0, code 2 shifts it left by one and fills bit 0 with 0, and code 3 passes the result unchanged.
- R6: With A-select 0 the A operand is the register named in bits 11:8. With A-select 1 it is the memory buffer.
- R7: Register-write enable stores the shifted result in the destination register. Buffer load stores it in the memory buffer, which drives the data output. Address load stores the low 12 bits of the B bus in the address register, which drives the address output.
- R8: Condition 0 steps to micro-address+1, wrapping from 255 to 0. Condition 1 jumps to the target when bit 15 of the unshifted ALU result is 1. Condition 2 jumps when the unshifted result is zero. Condition 3 always jumps.
- R9: A read bit raises the read strobe for the next cycle. If that next microword also has its read bit set, the buffer takes the read data at the end of that cycle, and this overrides a buffer load in the same microword. Otherwise the buffer is unchanged.
- R10: A write bit raises the write strobe for the next cycle, with the buffer on the data output and the address register on the address output. The write completes only if the next microword also has its write bit set.
- R11: A microword with both read and write bits set commits nothing. The halt output rises the next cycle and stays high until reset. While halted, the micro-address holds, both strobes are low, and the buffer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uaddr_o | output | 8 | Micro-address of the microword to execute |
| uword_i | input | 32 | Microword read from the control store at uaddr_o |
| mem_addr_o | output | 12 | Memory address (address register) |
| mem_wdata_o | output | 16 | Memory write data (memory buffer) |
| mem_rdata_i | input | 16 | Memory read data |
| mem_rd_o | output | 1 | Held read strobe |
| mem_wr_o | output | 1 | Held write strobe |
| halt_o | output | 1 | Core stopped by a read-and-write microword |

## Verification
The bench builds the core with its default parameters: a 16-bit datapath, a 12-bit memory address and a stack pointer that resets to 1024. At these values the dropping of the address's top four bits shows when the all-ones constant register drives the B bus. With 16-bit data, a carry out of bit 15 and a sign flip from 0x7FFF+1 both fall inside short directed programs. The 8-bit micro-address is small enough that a two-word program crosses the wrap from 255 to 0. Random ALU, shift, A-select and branch choices round this out, and each result is read back through the memory data output.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int SEL_W   = 4;
  localparam int UADDR_W = 8;
  localparam int UWORD_W = 32;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_AND  = 2'd1,
    ALU_PASS = 2'd2,
    ALU_INV  = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_RSVD  = 2'd3
  } sh_op_e;

  typedef enum logic [1:0] {
    NXT_SEQ     = 2'd0,
    NXT_IF_NEG  = 2'd1,
    NXT_IF_ZERO = 2'd2,
    NXT_JUMP    = 2'd3
  } nxt_e;

  // R3: packed most significant field first
  typedef struct packed {
    logic               a_from_buf;
    nxt_e               nxt;
    alu_op_e            alu;
    sh_op_e             sh;
    logic               buf_ld;
    logic               adr_ld;
    logic               rd;
    logic               wr;
    logic               reg_we;
    logic [SEL_W-1:0]   dst;
    logic [SEL_W-1:0]   bsel;
    logic [SEL_W-1:0]   asel;
    logic [UADDR_W-1:0] target;
  } uword_t;

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int DATA_W  = 16,
  parameter int NREG    = 16,
  parameter int SP_IDX  = 2,
  parameter int SP_INIT = 1024,
  parameter int K_LO    = 5,
  parameter int K_HI    = 9,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  asel,
  input  logic [SEL_W-1:0]  bsel,
  output logic [DATA_W-1:0] adata,
  output logic [DATA_W-1:0] bdata
);

  logic [DATA_W-1:0] rf [NREG];

  function automatic logic [DATA_W-1:0] const_word(input int idx);
    case (idx - K_LO)
      0:       const_word = '0;
      1:       const_word = DATA_W'(1);
      2:       const_word = '1;
      3:       const_word = DATA_W'(12'hFFF);
      default: const_word = DATA_W'(8'hFF);
    endcase
  endfunction

  function automatic logic is_const(input logic [SEL_W-1:0] s);
    is_const = (int'(s) >= K_LO) && (int'(s) <= K_HI);
  endfunction

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g >= K_LO && g <= K_HI) begin : g_const
      assign rf[g] = const_word(g);
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= (g == SP_IDX) ? SP_INIT[DATA_W-1:0] : '0;
        else if (we && wsel == SEL_W'(g))
          q <= wdata;
      end
      assign rf[g] = q;
    end
  end

  assign adata = rf[asel];
  assign bdata = rf[bsel];

  // R7: an enabled write to a writable register lands in that register
  p_reg_write_r7: assert property (@(posedge clk) disable iff (rst)
    (we && !is_const(wsel)) |=> rf[$past(wsel)] == $past(wdata));

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  input  sh_op_e            sh,
  output logic [DATA_W-1:0] y,
  output logic              neg,
  output logic              zero
);

  logic [DATA_W-1:0] pre;

  always_comb begin
    case (op)
      ALU_ADD:  pre = a + b;
      ALU_AND:  pre = a & b;
      ALU_PASS: pre = a;
      default:  pre = ~a;
    endcase
  end

  always_comb begin
    case (sh)
      SH_RIGHT: y = {1'b0, pre[DATA_W-1:1]};
      SH_LEFT:  y = {pre[DATA_W-2:0], 1'b0};
      default:  y = pre;
    endcase
  end

  assign neg  = pre[DATA_W-1];
  assign zero = (pre == '0);

endmodule

// File: rtl/mcpu_useq.sv
module mcpu_useq
  import mcpu_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  nxt_e          nxt,
  input  logic [AW-1:0] target,
  input  logic          neg,
  input  logic          zero,
  output logic [AW-1:0] mpc
);

  logic          take;
  logic [AW-1:0] mpc_nxt;

  always_comb begin
    case (nxt)
      NXT_IF_NEG:  take = neg;
      NXT_IF_ZERO: take = zero;
      NXT_JUMP:    take = 1'b1;
      default:     take = 1'b0;
    endcase
    mpc_nxt = take ? target : mpc + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      mpc <= '0;
    else if (adv) mpc <= mpc_nxt;
  end

  // R8: unconditional jump lands on the target
  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && nxt == NXT_JUMP) |=> mpc == $past(target));

  // R8: sequential step adds one with wrap
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && nxt == NXT_SEQ) |=> mpc == $past(mpc) + AW'(1));

  // R11: micro-address frozen when not advancing
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(mpc));

endmodule

// File: rtl/mcpu_memif.sv
module mcpu_memif #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              buf_ld,
  input  logic              adr_ld,
  input  logic [DATA_W-1:0] res,
  input  logic [MEM_AW-1:0] bbus_lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [MEM_AW-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              halt_q,
  output logic              commit
);

  logic conflict;
  logic rd_done;

  assign conflict = rd_req && wr_req;
  assign commit   = !halt_q && !conflict;
  assign rd_done  = commit && rd_q && rd_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q  <= '0;
      mbr_q  <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      rd_q <= commit && rd_req;
      wr_q <= commit && wr_req;
      if (!halt_q && conflict) halt_q <= 1'b1;
      if (commit && adr_ld) mar_q <= bbus_lo;
      if (rd_done)                mbr_q <= rdata;
      else if (commit && buf_ld)  mbr_q <= res;
    end
  end

  // R11: halt is sticky
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);

  // R11: no strobe while halted
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> (!rd_q && !wr_q));

  // R11: buffer unchanged once halted
  p_halt_buf_r11: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> $stable(mbr_q));

  // R9: completed read captures the read data
  p_read_done_r9: assert property (@(posedge clk) disable iff (rst)
    (commit && rd_q && rd_req) |=> mbr_q == $past(rdata));

  // R9: a read strobe follows only a committed read request
  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_q) |-> $past(rd_req && !halt_q));

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MEM_AW  = 12,
  parameter int SP_INIT = 1024
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [UADDR_W-1:0]   uaddr_o,
  input  logic [UWORD_W-1:0]   uword_i,
  output logic [MEM_AW-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic                 halt_o
);

  localparam int NREG = 1 << SEL_W;

  uword_t            uw;
  logic [DATA_W-1:0] abus, bbus, a_op, res, mbr;
  logic              neg, zero, commit;

  assign uw = uword_t'(uword_i);

  mcpu_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .SP_INIT(SP_INIT)
  ) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (commit && uw.reg_we),
    .wsel (uw.dst),
    .wdata(res),
    .asel (uw.asel),
    .bsel (uw.bsel),
    .adata(abus),
    .bdata(bbus)
  );

  assign a_op = uw.a_from_buf ? mbr : abus;

  mcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a   (a_op),
    .b   (bbus),
    .op  (uw.alu),
    .sh  (uw.sh),
    .y   (res),
    .neg (neg),
    .zero(zero)
  );

  mcpu_useq #(.AW(UADDR_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .adv   (commit),
    .nxt   (uw.nxt),
    .target(uw.target),
    .neg   (neg),
    .zero  (zero),
    .mpc   (uaddr_o)
  );

  mcpu_memif #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .rd_req (uw.rd),
    .wr_req (uw.wr),
    .buf_ld (uw.buf_ld),
    .adr_ld (uw.adr_ld),
    .res    (res),
    .bbus_lo(bbus[MEM_AW-1:0]),
    .rdata  (mem_rdata_i),
    .mar_q  (mem_addr_o),
    .mbr_q  (mbr),
    .rd_q   (mem_rd_o),
    .wr_q   (mem_wr_o),
    .halt_q (halt_o),
    .commit (commit)
  );

  assign mem_wdata_o = mbr;

endmodule

// File: tb/mcpu_core_bench.sv
`timescale 1ns/1ps
module mcpu_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  uaddr;
  logic [31:0] uword;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halt;

  logic [31:0] ucode [256];
  logic [15:0] bmem  [256];

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [11:0] wr_a;
  logic [15:0] wr_d;

  always #2.5 clk = ~clk;

  mcpu_core u_mcpu_core (
    .clk(clk), .rst(rst), .uaddr_o(uaddr), .uword_i(uword),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .halt_o(halt)
  );

  assign uword     = ucode[uaddr];
  assign mem_rdata = bmem[mem_addr[7:0]];

  // completed writes: strobe held and current microword repeats the write (R10)
  always @(posedge clk) begin
    if (!rst && mem_wr && ucode[uaddr][21]) begin
      wr_cnt <= wr_cnt + 1;
      wr_a   <= mem_addr;
      wr_d   <= mem_wdata;
    end
  end

  // R3 field packing
  function automatic logic [31:0] mk(input int amux, cond, alu, sh, mbr, mar,
                                     rd, wr, enc, c, b, a, ad);
    mk = {amux[0], cond[1:0], alu[1:0], sh[1:0], mbr[0], mar[0], rd[0], wr[0],
          enc[0], c[3:0], b[3:0], a[3:0], ad[7:0]};
  endfunction

  // returns {n, z, result}
  function automatic logic [17:0] model(input logic [15:0] a, b, input int op, sh);
    logic [15:0] p, r;
    case (op)
      0: p = a + b;
      1: p = a & b;
      2: p = a;
      default: p = ~a;
    endcase
    case (sh)
      1: r = {1'b0, p[15:1]};
      2: r = {p[14:0], 1'b0};
      default: r = p;
    endcase
    model = {p[15], p == 16'h0, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_ucode();
    for (int i = 0; i < 256; i++) ucode[i] = 32'h0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    do_reset();
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin : main
    logic [15:0] x, y, av;
    logic [17:0] m;
    int op, sh, am, cnd, w0;
    logic taken;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) bmem[i] = 16'h0;
    clear_ucode();

    // R1 reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 uaddr", {24'h0, uaddr}, 32'h0);
    check("R1 halt", {31'h0, halt}, 32'h0);
    check("R1 strobes", {30'h0, mem_rd, mem_wr}, 32'h0);
    check("R1 wdata", {16'h0, mem_wdata}, 32'h0);
    check("R1 addr", {20'h0, mem_addr}, 32'h0);

    // R1 stack pointer reset value
    clear_ucode();
    ucode[0] = mk(0,0,2,0,1,0,0,0,0,0,0,2,0);
    ucode[1] = mk(0,3,0,0,0,0,0,0,0,0,0,0,1);
    run(4);
    check("R1 sp reset", {16'h0, mem_wdata}, 32'd1024);

    // R2 constant registers ignore writes
    for (int k = 5; k <= 9; k++) begin
      logic [15:0] kv;
      kv = (k == 5) ? 16'h0000 : (k == 6) ? 16'h0001 : (k == 7) ? 16'hFFFF :
           (k == 8) ? 16'h0FFF : 16'h00FF;
      clear_ucode();
      ucode[0] = mk(0,0,2,0,0,0,0,0,1,k,0,(k == 7) ? 5 : 7,0);
      ucode[1] = mk(0,0,2,0,1,0,0,0,0,0,0,k,0);
      ucode[2] = mk(0,3,0,0,0,0,0,0,0,0,0,0,2);
      run(5);
      check("R2 constant", {16'h0, mem_wdata}, {16'h0, kv});
    end

    // R8 sequential wrap from 255 to 0
    clear_ucode();
    ucode[0]   = mk(0,3,0,0,0,0,0,0,0,0,0,0,255);
    do_reset();
    @(negedge clk);
    check("R8 jump to 255", {24'h0, uaddr}, 32'd255);
    @(negedge clk);
    check("R8 wrap to 0", {24'h0, uaddr}, 32'd0);

    // R9 read not repeated leaves buffer unchanged
    clear_ucode();
    bmem[1] = 16'hBEEF;
    ucode[0] = mk(0,0,0,0,0,1,1,0,0,0,6,0,0);
    ucode[2] = mk(0,3,0,0,0,0,0,0,0,0,0,0,2);
    do_reset();
    @(negedge clk);
    check("R9 read strobe", {31'h0, mem_rd}, 32'h1);
    check("R7 address load", {20'h0, mem_addr}, 32'h1);
    repeat (3) @(negedge clk);
    check("R9 incomplete read", {16'h0, mem_wdata}, 32'h0);

    // R9 completed read overrides buffer load
    ucode[1] = mk(0,0,2,0,1,0,1,0,0,0,0,7,0);
    run(4);
    check("R9 read wins", {16'h0, mem_wdata}, 32'hBEEF);

    // R10 completed write, R7 address truncated to 12 bits
    clear_ucode();
    ucode[0] = mk(0,0,2,0,1,1,0,0,0,0,7,9,0);
    ucode[1] = mk(0,0,0,0,0,0,0,1,0,0,0,0,0);
    ucode[2] = mk(0,0,0,0,0,0,0,1,0,0,0,0,0);
    ucode[3] = mk(0,3,0,0,0,0,0,0,0,0,0,0,3);
    w0 = wr_cnt;
    do_reset();
    repeat (2) @(negedge clk);
    check("R10 write strobe", {31'h0, mem_wr}, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 one write", wr_cnt - w0, 32'd1);
    check("R7 address 12 bits", {20'h0, wr_a}, 32'hFFF);
    check("R10 write data", {16'h0, wr_d}, 32'h00FF);

    // R10 single write word does not complete
    ucode[2] = 32'h0;
    w0 = wr_cnt;
    run(5);
    check("R10 incomplete write", wr_cnt - w0, 32'd0);

    // R11 halt
    clear_ucode();
    ucode[0] = mk(0,0,2,0,0,0,0,0,1,10,0,6,0);
    ucode[1] = mk(0,3,2,0,1,0,1,1,1,10,0,7,0);
    run(3);
    check("R11 halt high", {31'h0, halt}, 32'h1);
    check("R11 uaddr frozen", {24'h0, uaddr}, 32'h1);
    check("R11 strobes low", {30'h0, mem_rd, mem_wr}, 32'h0);
    check("R11 buffer kept", {16'h0, mem_wdata}, 32'h0);
    repeat (4) @(negedge clk);
    check("R11 halt sticky", {31'h0, halt}, 32'h1);
    check("R11 still frozen", {24'h0, uaddr}, 32'h1);

    // R4 R5 R6 R8 random and directed datapath programs
    for (int it = 0; it < 40; it++) begin
      x   = 16'($urandom);
      y   = 16'($urandom);
      op  = int'($urandom % 4);
      sh  = int'($urandom % 4);
      am  = int'($urandom % 2);
      cnd = 1 + int'($urandom % 2);
      case (it)
        0: begin x = 16'h7FFF; y = 16'h0001; op = 0; sh = 0; am = 0; cnd = 1; end
        1: begin x = 16'h00F0; y = 16'h0F00; op = 1; sh = 0; am = 0; cnd = 2; end
        2: begin x = 16'h8001; y = 16'h1234; op = 2; sh = 1; am = 0; cnd = 1; end
        3: begin x = 16'h8001; y = 16'h0000; op = 3; sh = 2; am = 0; cnd = 2; end
        4: begin x = 16'hFFFF; y = 16'h0001; op = 0; sh = 3; am = 0; cnd = 2; end
        5: begin x = 16'h0000; y = 16'h8000; op = 2; sh = 2; am = 1; cnd = 1; end
        default: ;
      endcase
      bmem[0] = x;
      bmem[1] = y;
      clear_ucode();
      ucode[0] = mk(0,0,0,0,0,1,1,0,0,0,5,0,0);
      ucode[1] = mk(0,0,0,0,0,0,1,0,0,0,0,0,0);
      ucode[2] = mk(1,0,2,0,0,1,1,0,1,10,6,0,0);
      ucode[3] = mk(0,0,0,0,0,0,1,0,0,0,0,0,0);
      ucode[4] = mk(1,0,2,0,0,0,0,0,1,11,0,0,0);
      ucode[5] = mk(am,cnd,op,sh,1,0,0,0,1,12,11,10,8'h40);
      ucode[6] = mk(0,3,0,0,0,0,0,0,0,0,0,0,6);
      ucode[8'h40] = mk(0,3,0,0,0,0,0,0,0,0,0,0,8'h40);
      av = am ? y : x;
      m  = model(av, y, op, sh);
      taken = (cnd == 1) ? m[17] : m[16];
      run(10);
      check("R4 R5 R6 result", {16'h0, mem_wdata}, {16'h0, m[15:0]});
      check("R8 branch", {24'h0, uaddr}, taken ? 32'h40 : 32'h6);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule